// File: doc/BRIEF.md
# Event Record Builder

This block assembles one event record per readout request for a single converter channel. When the readout controller raises a request, the block accepts it, samples the run number and the bunch number in that same cycle, and drains up to the requested number of edge measurements from the channel's synchronous measurement FIFO. The measurements are staged in an internal buffer. The block then streams a header word followed by the measurements over a valid/ready interface to the serializer. The last word of the record carries a last marker.

The header carries the actual number of measurements read. If the FIFO runs dry before the requested count is reached, the record is closed early and a truncation bit is set. Every measurement is emitted only after the header, so the whole record is staged first. One instance serves one channel. Several instances run side by side in the core clock domain and do not interact.

Top module: `evt_record_builder`

## Requirements
- R1: With the block idle, a high `req_start` on a rising edge is accepted. `busy` is high from the next cycle on, and while `busy` is low `out_valid` and `fifo_rd` stay low.
- R2: The first word of each record is the header. Its layout is: bits 7:0 the measurement count, bit 8 the truncation flag, bits 20:9 the bunch number, bits 28:21 the run number, and bits 31:29 zero.
- R3: The run number and bunch number in the header are the values on `run_num` and `bunch_num` on the accepting edge. Later changes to these inputs have no effect on the record.
- R4: When the FIFO holds at least `req_len` entries, exactly `req_len` entries are read. They follow the header in FIFO order, one per word, in bits 22:0 with bits 31:23 zero. The header count equals `req_len` and the truncation bit is 0.
- R5: When the FIFO holds fewer than `req_len` entries, all of them are read and emitted. The header count equals the number read and the truncation bit is 1.
- R6: Each output word is transferred on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. `out_last` is high on the final word of the record only.
- R7: A `req_start` while `busy` is high is ignored. It starts no second record and leaves the current record unchanged.
- R8: With `req_len` equal to 0, the record is the header alone, with count 0, truncation bit 0 and `out_last` high.
- R9: `busy` falls in the cycle after the final word is transferred, and the block then accepts a new request.
- R10: The FIFO is never read while it is empty or while the block is idle, and never more than `req_len` times per record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Transmit request from the readout controller |
| req_len | input | 8 | Number of measurements wanted in the record |
| run_num | input | 8 | Run number from the command decoder |
| bunch_num | input | 12 | Bunch number from the orbit counter |
| fifo_empty | input | 1 | Measurement FIFO empty flag |
| fifo_rd | output | 1 | Measurement FIFO read enable |
| fifo_q | input | 23 | Measurement FIFO read data, valid the cycle after a read |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Serializer ready |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Final word of the record |
| busy | output | 1 | Record in progress |

## Verification
After the accepting edge, `busy` is due in the next cycle, and the first FIFO read goes out in that same cycle. The header can appear no earlier than three cycles after the last FIFO read. Output words follow at most one every two cycles, and `busy` is due low in the cycle after the final transfer. The bench drives inputs and samples outputs on the falling edge. It sets `out_ready` for the coming edge before it looks at `out_valid`, so a word is scored exactly on the edge where it is transferred. It never assumes a fixed arrival cycle for stream words, and it checks `busy` and the FIFO read count at the fixed cycles given above.

// File: rtl/evt_rec_pkg.sv
package evt_rec_pkg;

  typedef enum logic [1:0] {
    BLD_IDLE,
    BLD_DRAIN,
    BLD_EMIT
  } bld_state_e;

  typedef enum logic [1:0] {
    EM_IDLE,
    EM_SHOW,
    EM_LOAD
  } emit_state_e;

endpackage

// File: rtl/evt_rec_ram.sv
module evt_rec_ram #(
  parameter int DW = 23,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // simple dual-port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evt_rec_drain.sv
module evt_rec_drain #(
  parameter int MEAS_W = 23,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic              fifo_empty,
  input  logic [MEAS_W-1:0] fifo_q,
  output logic              fifo_rd,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_addr,
  output logic [MEAS_W-1:0] wr_data,
  output logic              done,
  output logic [CNT_W-1:0]  got,
  output logic              trunc
);
  logic             active;
  logic             pend;
  logic [CNT_W-1:0] tgt;
  logic [CNT_W-1:0] issued;
  logic [CNT_W-1:0] waddr;

  assign fifo_rd = active && (issued != tgt) && !fifo_empty;
  assign wr_en   = pend;
  assign wr_addr = waddr;
  assign wr_data = fifo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pend   <= 1'b0;
      tgt    <= '0;
      issued <= '0;
      waddr  <= '0;
      done   <= 1'b0;
      got    <= '0;
      trunc  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        pend   <= 1'b0;
        tgt    <= len;
        issued <= '0;
        waddr  <= '0;
      end else if (active) begin
        pend <= fifo_rd;
        if (fifo_rd) issued <= issued + 1'b1;
        if (pend)    waddr  <= waddr + 1'b1;
        // no read this cycle and nothing in flight: record body is closed
        if (!fifo_rd && !pend) begin
          active <= 1'b0;
          done   <= 1'b1;
          got    <= issued;
          trunc  <= (issued != tgt);
        end
      end
    end
  end

  p_read_bound_r10: assert property (@(posedge clk) disable iff (rst)
    active |-> (issued <= tgt));

  p_store_follows_read_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(fifo_rd));

  p_no_read_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_rd);
endmodule

// File: rtl/evt_rec_emit.sv
module evt_rec_emit
  import evt_rec_pkg::*;
#(
  parameter int MEAS_W  = 23,
  parameter int CNT_W   = 8,
  parameter int RUN_W   = 8,
  parameter int BUNCH_W = 12,
  parameter int OUT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               trunc,
  input  logic [RUN_W-1:0]   run,
  input  logic [BUNCH_W-1:0] bunch,
  output logic [CNT_W-1:0]   raddr,
  input  logic [MEAS_W-1:0]  rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_last
);
  localparam int HDR_W = RUN_W + BUNCH_W + 1 + CNT_W;
  localparam int HPAD  = OUT_W - HDR_W;
  localparam int DPAD  = OUT_W - MEAS_W;

  emit_state_e      st;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q;
  logic [OUT_W-1:0] hdr;

  assign hdr   = {{HPAD{1'b0}}, run, bunch, trunc, cnt};
  assign raddr = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EM_IDLE;
      idx       <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      case (st)
        EM_IDLE: begin
          if (start) begin
            out_data  <= hdr;
            out_valid <= 1'b1;
            out_last  <= (cnt == '0);
            cnt_q     <= cnt;
            idx       <= '0;
            st        <= EM_SHOW;
          end
        end
        EM_SHOW: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            st        <= out_last ? EM_IDLE : EM_LOAD;
          end
        end
        EM_LOAD: begin
          // buffer word at idx was read during the SHOW cycle
          out_data  <= {{DPAD{1'b0}}, rdata};
          out_valid <= 1'b1;
          out_last  <= (idx == cnt_q - 1'b1);
          idx       <= idx + 1'b1;
          st        <= EM_SHOW;
        end
        default: st <= EM_IDLE;
      endcase
    end
  end

  p_hold_while_stalled_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_no_word_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/evt_record_builder.sv
module evt_record_builder
  import evt_rec_pkg::*;
#(
  parameter int MEAS_W  = 23,
  parameter int CNT_W   = 8,
  parameter int RUN_W   = 8,
  parameter int BUNCH_W = 12,
  parameter int OUT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_start,
  input  logic [CNT_W-1:0]   req_len,
  input  logic [RUN_W-1:0]   run_num,
  input  logic [BUNCH_W-1:0] bunch_num,
  input  logic               fifo_empty,
  output logic               fifo_rd,
  input  logic [MEAS_W-1:0]  fifo_q,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_last,
  output logic               busy
);
  bld_state_e         st;
  logic [RUN_W-1:0]   cap_run;
  logic [BUNCH_W-1:0] cap_bunch;
  logic               accept;

  logic               d_done;
  logic [CNT_W-1:0]   d_got;
  logic               d_trunc;
  logic               b_we;
  logic [CNT_W-1:0]   b_waddr;
  logic [MEAS_W-1:0]  b_wdata;
  logic [CNT_W-1:0]   b_raddr;
  logic [MEAS_W-1:0]  b_rdata;

  assign accept = (st == BLD_IDLE) && req_start;
  assign busy   = (st != BLD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BLD_IDLE;
      cap_run   <= '0;
      cap_bunch <= '0;
    end else begin
      case (st)
        BLD_IDLE: begin
          if (req_start) begin
            cap_run   <= run_num;
            cap_bunch <= bunch_num;
            st        <= BLD_DRAIN;
          end
        end
        BLD_DRAIN: if (d_done) st <= BLD_EMIT;
        BLD_EMIT:  if (out_valid && out_ready && out_last) st <= BLD_IDLE;
        default:   st <= BLD_IDLE;
      endcase
    end
  end

  evt_rec_drain #(.MEAS_W(MEAS_W), .CNT_W(CNT_W)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .len        (req_len),
    .fifo_empty (fifo_empty),
    .fifo_q     (fifo_q),
    .fifo_rd    (fifo_rd),
    .wr_en      (b_we),
    .wr_addr    (b_waddr),
    .wr_data    (b_wdata),
    .done       (d_done),
    .got        (d_got),
    .trunc      (d_trunc)
  );

  evt_rec_ram #(.DW(MEAS_W), .AW(CNT_W)) u_buf (
    .clk   (clk),
    .we    (b_we),
    .waddr (b_waddr),
    .wdata (b_wdata),
    .raddr (b_raddr),
    .rdata (b_rdata)
  );

  evt_rec_emit #(
    .MEAS_W (MEAS_W),
    .CNT_W  (CNT_W),
    .RUN_W  (RUN_W),
    .BUNCH_W(BUNCH_W),
    .OUT_W  (OUT_W)
  ) u_emit (
    .clk       (clk),
    .rst       (rst),
    .start     (d_done),
    .cnt       (d_got),
    .trunc     (d_trunc),
    .run       (cap_run),
    .bunch     (cap_bunch),
    .raddr     (b_raddr),
    .rdata     (b_rdata),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!out_valid && !fifo_rd));

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_start) |=> busy);

  p_snapshot_held_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cap_run) && $stable(cap_bunch)));

  p_release_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !busy);
endmodule

// File: tb/evt_record_builder_tb.sv
module evt_record_builder_tb;
  localparam int MEAS_W = 23;
  localparam int CNT_W  = 8;
  localparam int RUN_W  = 8;
  localparam int BUN_W  = 12;
  localparam int OUT_W  = 32;
  localparam int FDEP   = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst;
  logic              req_start;
  logic [CNT_W-1:0]  req_len;
  logic [RUN_W-1:0]  run_num;
  logic [BUN_W-1:0]  bunch_num;
  logic              fifo_empty;
  logic              fifo_rd;
  logic [MEAS_W-1:0] fifo_q;
  logic              out_valid;
  logic              out_ready;
  logic [OUT_W-1:0]  out_data;
  logic              out_last;
  logic              busy;

  int total = 0;
  int bad   = 0;
  int wd    = 0;

  evt_record_builder u_dut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_len(req_len),
    .run_num(run_num), .bunch_num(bunch_num), .fifo_empty(fifo_empty),
    .fifo_rd(fifo_rd), .fifo_q(fifo_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .busy(busy)
  );

  // bench FIFO model: data one cycle after a read
  logic [MEAS_W-1:0] fmem [0:FDEP-1];
  int wp = 0;
  int rp = 0;
  assign fifo_empty = (wp == rp);
  always @(posedge clk) begin
    if (fifo_rd) begin
      fifo_q <= fmem[rp % FDEP];
      rp     <= rp + 1;
    end
  end

  // free-running bunch number
  always @(negedge clk) begin
    if (rst) bunch_num <= 12'h015;
    else     bunch_num <= bunch_num + 12'd7;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MEAS_W-1:0] pat(input int s);
    return MEAS_W'((s * 40503 + 12345) ^ (s << 7));
  endfunction

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      fmem[wp % FDEP] = pat(wp);
      wp = wp + 1;
    end
  endtask

  task automatic run_case(input int len, input int npush, input int mode, input logic [7:0] run);
    int level, got, rp0, nword, guard;
    bit trunc, done, pulsed;
    logic [BUN_W-1:0] eb;
    logic [OUT_W-1:0] exp_w;
    @(negedge clk);
    push(npush);
    level = wp - rp;
    got   = (level < len) ? level : len;
    trunc = (level < len);
    rp0   = rp;
    req_start = 1'b1;
    req_len   = CNT_W'(len);
    run_num   = run;
    #1 eb = bunch_num;
    @(negedge clk);
    req_start = 1'b0;
    run_num   = ~run;                     // R3: later change must not matter
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    nword = 0; done = 0; pulsed = 0; guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      req_start = 1'b0;
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = guard[0];
        default: out_ready = (guard % 3 == 0);
      endcase
      #1;
      if (out_valid && out_ready) begin
        if (nword == 0) begin
          chk(out_data[31:29] == 3'b000, "R2 header pad", out_data[31:29], 0);
          chk(out_data[28:21] == run, "R3 run field", out_data[28:21], run);
          chk(out_data[20:9] == eb, "R3 bunch field", out_data[20:9], eb);
          chk(out_data[8] == trunc, "R5 trunc bit", out_data[8], trunc);
          chk(out_data[7:0] == 8'(got), "R4 count field", out_data[7:0], got);
          if (len == 0)
            chk(out_last && !out_data[8], "R8 header-only record", out_last, 1);
        end else begin
          exp_w = {9'b0, fmem[(rp0 + nword - 1) % FDEP]};
          chk(out_data == exp_w, trunc ? "R5 data word" : "R4 data word", out_data, exp_w);
        end
        chk(out_last == (nword == got), "R6 last marker", out_last, (nword == got));
        if (out_last) done = 1;
        else if (!pulsed) begin
          req_start = 1'b1;                 // R7: must be ignored
          req_len   = 8'd3;
          run_num   = 8'hA5;
          pulsed    = 1;
        end
        nword++;
      end
    end
    chk(done, "R6 record completed", done, 1);
    chk(nword == got + 1, "R4 word total", nword, got + 1);
    @(negedge clk);
    req_start = 1'b0;
    out_ready = 1'b0;
    chk(!busy, "R9 busy released", busy, 0);
    chk(rp - rp0 == got, "R10 fifo reads", rp - rp0, got);
    repeat (4) @(negedge clk);
    chk(!out_valid && !busy && (rp - rp0 == got), "R7 no extra record", out_valid, 0);
  endtask

  initial begin
    rst = 1'b1; req_start = 1'b0; req_len = '0; run_num = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid && !fifo_rd, "R1 reset state", {busy, out_valid, fifo_rd}, 0);
    run_case(0,   0,   0, 8'h11);
    run_case(1,   1,   0, 8'h22);
    run_case(3,   5,   1, 8'h33);
    run_case(5,   0,   2, 8'h44);
    run_case(4,   4,   2, 8'h55);
    run_case(17,  10,  1, 8'h66);
    run_case(255, 255, 0, 8'h77);
    run_case(255, 300, 2, 8'h88);
    run_case(0,   0,   1, 8'h99);
    run_case(50,  0,   0, 8'hAA);
    run_case(8,   0,   1, 8'hBB);
    for (int n = 0; n < 25; n++)
      run_case(n, (n * 3) % 7 + n / 2, n % 3, 8'(n * 9 + 1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule